// File: doc/BRIEF.md
# Segmented-Paged Address Translator

This block maps 32-bit virtual addresses onto 32-bit physical addresses. The virtual space is cut into four sections, each holding up to 8K segments. Every segment has a descriptor that sets its mode. A contiguous segment of at most 128K bytes is placed at a base address plus the offset. A paged segment holds up to sixty-four 2K-byte pages, and each page is mapped on its own. Each request is checked against a small segment descriptor cache. For paged segments it is also checked against a page descriptor cache.

A requester drives a virtual address with a valid strobe. One cycle later a registered response arrives. It carries either a physical address with the hit flag set, or a code that explains why no address could be formed. Descriptors reach the block only through a fill port that an outside agent drives. The block reports misses and does not resolve them.

Top module: `seg_xlat_unit`

## Requirements
- R1: Every cycle with `req_valid` high yields `rsp_valid` high on the next cycle. A cycle without a request yields `rsp_valid` low on the next cycle.
- R2: When no valid segment entry matches the request's section and segment bits `[31:17]`, the response has code 1 (segment miss). In that case `rsp_hit` is low and `rsp_pa` is zero. Every non-hit response has `rsp_pa` zero and a nonzero code, and a hit always carries code 0.
- R3: For a contiguous segment (descriptor mode bit 0) whose offset `va[16:0]` does not exceed the stored limit, the response has code 0 and `rsp_hit` high. `rsp_pa` then equals base·32 plus the offset, modulo 2^32.
- R4: For a contiguous segment whose offset is greater than the stored limit, the response has code 3 (bounds fault) and `rsp_hit` low.
- R5: For a paged segment (mode bit 1) with a page entry that matches `va[31:11]`, `rsp_pa` is the 21-bit frame number in bits `[31:11]`.
- R6: For a paged segment that hits in the segment cache but has no matching page entry, the response has code 2 (page miss).
- R7: In paged mode, `rsp_pa[10:0]` is a copy of `va[10:0]`.
- R8: Both caches are direct-mapped, indexed by the low bits of their key and tagged with the rest. A fill whose key aliases a resident entry replaces it, and the older key then misses.
- R9: A cycle with `flush` high invalidates every entry of both caches. A lookup in that cycle or later misses until a fill restores an entry. A fill in the flush cycle itself survives.
- R10: A lookup in the same cycle as a fill to the entry it needs uses the descriptor being filled.
- R11: After reset `rsp_valid` and `rsp_hit` are low and both caches are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all descriptors in both caches |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| fill_en | input | 1 | Write one descriptor this cycle |
| fill_page | input | 1 | 1 writes the page cache, 0 writes the segment cache |
| fill_va | input | 32 | Virtual address whose key selects the entry written |
| fill_paged | input | 1 | Segment mode: 1 paged, 0 contiguous |
| fill_base | input | 27 | Segment base address divided by 32 |
| fill_limit | input | 17 | Largest legal offset of a contiguous segment |
| fill_frame | input | 21 | Physical frame number for a page descriptor |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_code | output | 2 | 0 ok, 1 segment miss, 2 page miss, 3 bounds fault |
| rsp_pa | output | 32 | Physical address, zero when not a hit |

## Verification
The main function is tried on a small set of resident descriptors. One is a contiguous segment with a 2K-aligned base, one has a base that is only 32-byte aligned, and one is a paged segment with a single page loaded. Offsets are placed just inside and just beyond the limit, which separates correct translations from bounds faults. Page numbers with and without a cached page tell page misses apart from hits. Addresses that alias a resident index under a different tag tell a true tag compare apart from an index-only match. Directed cases then cover a lookup that coincides with a fill, a flush, refill after a flush, and lookup before any fill.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W      = 32;
    localparam int OFF_W     = 17;
    localparam int BYTE_W    = 11;
    localparam int BASE_W    = 27;
    localparam int FRAME_W   = VA_W - BYTE_W;
    localparam int SEG_KEY_W = VA_W - OFF_W;
    localparam int PG_KEY_W  = VA_W - BYTE_W;
    localparam int ALIGN_W   = VA_W - BASE_W;

    typedef enum logic [1:0] {
        XL_OK        = 2'd0,
        XL_SEG_MISS  = 2'd1,
        XL_PAGE_MISS = 2'd2,
        XL_BOUNDS    = 2'd3
    } xl_code_e;

    typedef struct packed {
        logic              paged;
        logic [BASE_W-1:0] base;
        logic [OFF_W-1:0]  limit;
    } seg_desc_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
    } page_desc_t;

    function automatic logic [SEG_KEY_W-1:0] seg_key(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic logic [PG_KEY_W-1:0] page_key(input logic [VA_W-1:0] va);
        return va[VA_W-1:BYTE_W];
    endfunction

    function automatic logic [VA_W-1:0] contig_pa(input logic [BASE_W-1:0] base,
                                                  input logic [OFF_W-1:0]  off);
        return {base, {ALIGN_W{1'b0}}} + {{(VA_W-OFF_W){1'b0}}, off};
    endfunction

endpackage

// File: rtl/xlat_dm_cache.sv
module xlat_dm_cache #(
    parameter int KEY_W  = 15,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [KEY_W-1:0]  rd_key,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = KEY_W - IDX_W;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [DATA_W-1:0]  dat_q [ENTRIES];

    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [TAG_W-1:0] wr_tag, rd_tag;
    assign wr_idx = wr_key[IDX_W-1:0];
    assign wr_tag = wr_key[KEY_W-1:IDX_W];
    assign rd_idx = rd_key[IDX_W-1:0];
    assign rd_tag = rd_key[KEY_W-1:IDX_W];

    // Flush clears everything; a fill in the same cycle still lands.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (flush) vld_q <= '0;
            if (wr_en) vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            dat_q[wr_idx] <= wr_data;
        end
    end

    // Read sees the state as it will be after this cycle's flush and fill.
    logic             byp;
    logic             eff_v;
    logic [TAG_W-1:0] eff_tag;
    always_comb begin
        byp     = wr_en && (wr_idx == rd_idx);
        eff_v   = byp ? 1'b1 : (!flush && vld_q[rd_idx]);
        eff_tag = byp ? wr_tag : tag_q[rd_idx];
        rd_data = byp ? wr_data : dat_q[rd_idx];
        rd_hit  = eff_v && (eff_tag == rd_tag);
    end

    // R10: a fill to the very key being read is visible in that cycle
    p_fill_bypass_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_key == wr_key) |-> (rd_hit && rd_data == wr_data));

    // R9: after a flush with no fill since, nothing hits
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && !$past(wr_en) && !wr_en) |-> !rd_hit);

endmodule

// File: rtl/xlat_resolve.sv
module xlat_resolve
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            seg_hit,
    input  seg_desc_t       sd,
    input  logic            pg_hit,
    input  page_desc_t      pd,
    output logic            hit,
    output xl_code_e        code,
    output logic [VA_W-1:0] pa
);
    logic [OFF_W-1:0] off;
    assign off = va[OFF_W-1:0];

    always_comb begin
        code = XL_OK;
        pa   = '0;
        if (!seg_hit) begin
            code = XL_SEG_MISS;
        end else if (sd.paged) begin
            if (pg_hit) pa = {pd.frame, va[BYTE_W-1:0]};
            else        code = XL_PAGE_MISS;
        end else if (off > sd.limit) begin
            code = XL_BOUNDS;
        end else begin
            pa = contig_pa(sd.base, off);
        end
        hit = (code == XL_OK);
    end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import xlat_pkg::*;
#(
    parameter int SEG_IDX_W = 4,
    parameter int PG_IDX_W  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    input  logic        fill_en,
    input  logic        fill_page,
    input  logic [31:0] fill_va,
    input  logic        fill_paged,
    input  logic [26:0] fill_base,
    input  logic [16:0] fill_limit,
    input  logic [20:0] fill_frame,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [1:0]  rsp_code,
    output logic [31:0] rsp_pa
);
    localparam int SD_W = $bits(seg_desc_t);
    localparam int PD_W = $bits(page_desc_t);

    seg_desc_t  fill_sd, rd_sd;
    page_desc_t fill_pd, rd_pd;
    logic [SD_W-1:0] sd_rd_bits;
    logic [PD_W-1:0] pd_rd_bits;
    logic seg_hit, pg_hit;

    always_comb begin
        fill_sd.paged = fill_paged;
        fill_sd.base  = fill_base;
        fill_sd.limit = fill_limit;
        fill_pd.frame = fill_frame;
    end
    assign rd_sd = sd_rd_bits;
    assign rd_pd = pd_rd_bits;

    xlat_dm_cache #(.KEY_W(SEG_KEY_W), .IDX_W(SEG_IDX_W), .DATA_W(SD_W)) u_seg_cache (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (fill_en && !fill_page),
        .wr_key  (seg_key(fill_va)),
        .wr_data (fill_sd),
        .rd_key  (seg_key(req_va)),
        .rd_hit  (seg_hit),
        .rd_data (sd_rd_bits)
    );

    xlat_dm_cache #(.KEY_W(PG_KEY_W), .IDX_W(PG_IDX_W), .DATA_W(PD_W)) u_page_cache (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (fill_en && fill_page),
        .wr_key  (page_key(fill_va)),
        .wr_data (fill_pd),
        .rd_key  (page_key(req_va)),
        .rd_hit  (pg_hit),
        .rd_data (pd_rd_bits)
    );

    logic            nx_hit;
    xl_code_e        nx_code;
    logic [VA_W-1:0] nx_pa;

    xlat_resolve u_resolve (
        .va      (req_va),
        .seg_hit (seg_hit),
        .sd      (rd_sd),
        .pg_hit  (pg_hit),
        .pd      (rd_pd),
        .hit     (nx_hit),
        .code    (nx_code),
        .pa      (nx_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_code  <= XL_OK;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && nx_hit;
            if (req_valid) begin
                rsp_code <= nx_code;
                rsp_pa   <= nx_pa;
            end
        end
    end

    // R1: one response per request, exactly one cycle later
    p_rsp_latency_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2: hit flag and code agree; failed lookups carry no address
    p_hit_code_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit == (rsp_code == XL_OK)));
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_pa == '0));

    // R7: a paged hit keeps the byte field of the request
    p_byte_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && seg_hit && rd_sd.paged && pg_hit)
            |=> (rsp_pa[BYTE_W-1:0] == $past(req_va[BYTE_W-1:0])));

endmodule

// File: tb/test_seg_xlat_unit.sv
module test_seg_xlat_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        req_valid;
    logic [31:0] req_va;
    logic        fill_en;
    logic        fill_page;
    logic [31:0] fill_va;
    logic        fill_paged;
    logic [26:0] fill_base;
    logic [16:0] fill_limit;
    logic [20:0] fill_frame;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_pa;

    always #5 clk = ~clk;

    seg_xlat_unit i_seg_xlat_unit (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_va(req_va),
        .fill_en(fill_en), .fill_page(fill_page), .fill_va(fill_va),
        .fill_paged(fill_paged), .fill_base(fill_base), .fill_limit(fill_limit),
        .fill_frame(fill_frame),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_code(rsp_code), .rsp_pa(rsp_pa)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct packed {
        logic [31:0] va;
        logic        hit;
        logic [1:0]  code;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h000A1234, 1'b1, 2'd0, 32'h00021234},  // R3 aligned base
        '{32'h000AFFFF, 1'b1, 2'd0, 32'h0002FFFF},  // R3 offset equals limit
        '{32'h000B0000, 1'b0, 2'd3, 32'h00000000},  // R4 one past limit
        '{32'h40041FFF, 1'b1, 2'd0, 32'h055E6FFF},  // R5 R7 paged hit
        '{32'h40041800, 1'b1, 2'd0, 32'h055E6800},  // R7 byte zero
        '{32'h40042000, 1'b0, 2'd2, 32'h00000000},  // R6 page absent
        '{32'h800A0000, 1'b0, 2'd1, 32'h00000000},  // R2 R8 index alias, tag differs
        '{32'h000C0000, 1'b0, 2'd1, 32'h00000000},  // R2 empty slot
        '{32'hFFFFFFFF, 1'b1, 2'd0, 32'h0002245F},  // R3 32-byte base, max offset
        '{32'hFFFE0000, 1'b1, 2'd0, 32'h00002460}   // R3 32-byte base, zero offset
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush = 1'b0; req_valid = 1'b0; req_va = '0;
        fill_en = 1'b0; fill_page = 1'b0; fill_va = '0; fill_paged = 1'b0;
        fill_base = '0; fill_limit = '0; fill_frame = '0;
    endtask

    task automatic set_seg(input logic [31:0] va, input logic paged,
                           input logic [26:0] base, input logic [16:0] limit);
        fill_en = 1'b1; fill_page = 1'b0; fill_va = va;
        fill_paged = paged; fill_base = base; fill_limit = limit;
    endtask

    task automatic set_page(input logic [31:0] va, input logic [20:0] frame);
        fill_en = 1'b1; fill_page = 1'b1; fill_va = va; fill_frame = frame;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    // Drive at negedge, the response register loads at the next posedge,
    // sample at the negedge after that.
    task automatic expect_rsp(input string tag, input logic hit,
                              input logic [1:0] code, input logic [31:0] pa);
        check({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
        check({tag, " hit"},   {31'b0, rsp_hit},   {31'b0, hit});
        check({tag, " code"},  {30'b0, rsp_code},  {30'b0, code});
        check({tag, " pa"},    rsp_pa,             pa);
    endtask

    task automatic lookup(input string tag, input logic [31:0] va, input logic hit,
                          input logic [1:0] code, input logic [31:0] pa);
        req_valid = 1'b1; req_va = va;
        step();
        expect_rsp(tag, hit, code, pa);
    endtask

    initial begin
        #(10 * 100000);
        n_fail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        check("R11 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        check("R11 rsp_hit after reset",   {31'b0, rsp_hit},   32'd0);
        lookup("R11 empty caches", 32'h000A1234, 1'b0, 2'd1, 32'h0);

        // Load descriptors
        set_seg(32'h000A0000, 1'b0, 27'h0001000, 17'h0FFFF); step();
        set_seg(32'h40040000, 1'b1, 27'h0000000, 17'h00000); step();
        set_seg(32'hFFFE0000, 1'b0, 27'h0000123, 17'h1FFFF); step();
        set_page(32'h40041800, 21'h0ABCD);                     step();

        for (int i = 0; i < NV; i++) begin
            lookup($sformatf("vector %0d", i), VECS[i].va, VECS[i].hit,
                   VECS[i].code, VECS[i].pa);
        end

        // R1: no request, no response
        step();
        check("R1 idle cycle", {31'b0, rsp_valid}, 32'd0);

        // R10: segment fill and lookup in one cycle
        set_seg(32'h000E0000, 1'b0, 27'h0000010, 17'h0FFFF);
        lookup("R10 segment bypass", 32'h000E0004, 1'b1, 2'd0, 32'h00000204);

        // R10: page fill and lookup in one cycle
        set_page(32'h40042000, 21'h0000001);
        lookup("R10 page bypass", 32'h40042000, 1'b1, 2'd0, 32'h00000800);

        // R8: aliasing fill evicts the older key
        set_seg(32'h800A0000, 1'b0, 27'h0000400, 17'h0FFFF); step();
        lookup("R8 new key hits",   32'h800A0010, 1'b1, 2'd0, 32'h00008010);
        lookup("R8 old key evicted", 32'h000A1234, 1'b0, 2'd1, 32'h0);

        // R9: flush empties both caches
        flush = 1'b1; step();
        lookup("R9 paged after flush",      32'h40041FFF, 1'b0, 2'd1, 32'h0);
        lookup("R9 contiguous after flush", 32'hFFFFFFFF, 1'b0, 2'd1, 32'h0);
        flush = 1'b1;
        lookup("R9 lookup in flush cycle",  32'h000E0004, 1'b0, 2'd1, 32'h0);

        // R9: a fill during the flush cycle survives
        flush = 1'b1;
        set_seg(32'h000A0000, 1'b0, 27'h0001000, 17'h0FFFF); step();
        lookup("R9 refill after flush", 32'h000A1234, 1'b1, 2'd0, 32'h00021234);

        // R6 then R5: page loaded later turns a page miss into a hit
        set_seg(32'h40040000, 1'b1, 27'h0, 17'h0); step();
        lookup("R6 page gone after flush", 32'h40041FFF, 1'b0, 2'd2, 32'h0);
        set_page(32'h40041800, 21'h1FFFFF); step();
        lookup("R5 top frame", 32'h40041ABC, 1'b1, 2'd0, 32'hFFFFFABC);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule